// File: doc/BRIEF.md
# Packet buffer DMA controller

This block moves 32-bit packet words between one port of a 512-line dual-port RAM and a word stream. A host issues a 32-bit command word together with a one-cycle go pulse. The command names a buffer, picks an operation (clear, fill from the stream, or drain to the stream), gives an address stride and bounds the transfer with an inclusive first and last line. Several instances can share one command bus, and each one reacts only to its own buffer index.

In drain mode, the word at the first line is fetched before the consumer asks for it. Every read strobe then moves the stream on to the next line, and the start and end of the packet are marked by the line range. In fill mode, every write strobe stores the incoming word at the current line. The block shows whether it can take more words and whether the range is exhausted. Both directions also accept an upstream "finished" pulse and an upstream "abort" pulse. The outcome stays latched on the done and error outputs until the next command for this buffer.

The RAM is outside the block. It is expected to return read data one cycle after an enabled read, and to hold its read output while its enable is low. The consumer watches the word-available output and strobes only while it is high.

Top module: `pktbuf_dma`

## Requirements
- R1: After reset, the outputs wr_ready_o, wr_full_o, done_o, error_o, ram_en_o and rd_avail_o are all low.
- R2: A command takes effect only on a cycle with cmd_go high, cmd_word[31:28] equal to BUF_IDX and cmd_word[27:25] zero. Any other command changes nothing. The word carries clear at bit 24, write at bit 23, read at bit 22, step at [21:18], last line at [17:9] and first line at [8:0].
- R3: In the cycle after an accepted read command, the RAM is read (ram_en_o=1, ram_we_o=0) at the first line. In the following cycle rd_avail_o and rd_sop_o are high and rd_data_o holds that word.
- R4: Each rd_strobe_i while rd_avail_o is high moves the stream on, and the next line's word is on rd_data_o in the next cycle. While rd_avail_o is high and no strobe is given, ram_en_o stays low.
- R5: rd_eop_o is high while the last line is presented. A strobe on that word makes done_o high and rd_avail_o low in the next cycle. For a one-line range, rd_sop_o and rd_eop_o are high together.
- R6: After an accepted write command, wr_ready_o is high. Each wr_strobe_i writes wr_data_i to the current line (ram_en_o=ram_we_o=1 in that cycle), starting at the first line.
- R7: Writing the last line drops wr_ready_o and raises wr_full_o in the next cycle. A further wr_strobe_i while full writes nothing and ends the transfer with error_o.
- R8: An upstream finished pulse (wr_last_i, rd_last_i) ends the transfer with done_o. An upstream abort (wr_abort_i, rd_abort_i) ends it with error_o and blocks a write in that cycle.
- R9: done_o and error_o are never high together. Each one holds until the next accepted command.
- R10: A clear command returns the block to idle with done_o, error_o, wr_ready_o, wr_full_o and rd_avail_o low.
- R11: When several operation bits are set, clear wins over write and write wins over read. An accepted word with no operation bit set changes nothing.
- R12: The line address moves by the step field after each word, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 32 | Packed command |
| cmd_go | input | 1 | One-cycle command launch |
| done_o | output | 1 | Transfer ended normally |
| error_o | output | 1 | Transfer ended in error |
| ram_en_o | output | 1 | RAM port enable |
| ram_we_o | output | 1 | RAM port write enable |
| ram_addr_o | output | 9 | RAM line address |
| ram_wdata_o | output | 32 | Data to RAM |
| ram_rdata_i | input | 32 | Data from RAM |
| wr_data_i | input | 32 | Incoming stream word |
| wr_strobe_i | input | 1 | Store incoming word |
| wr_last_i | input | 1 | Producer finished |
| wr_abort_i | input | 1 | Producer abort |
| wr_ready_o | output | 1 | Fill armed, space left |
| wr_full_o | output | 1 | Fill range exhausted |
| rd_data_o | output | 32 | Outgoing stream word |
| rd_strobe_i | input | 1 | Consumer takes word |
| rd_last_i | input | 1 | Consumer finished |
| rd_abort_i | input | 1 | Consumer abort |
| rd_avail_o | output | 1 | A word is presented |
| rd_sop_o | output | 1 | Presented word is first |
| rd_eop_o | output | 1 | Presented word is last |

## Verification
The prefetch read is due in the cycle after the go pulse. The first word with its start mark is due one cycle after that. Each later word, and every done, error or full flag, is due one cycle after the strobe or upstream pulse that causes it. The bench drives inputs just after a rising edge and reads outputs on the falling edge of exactly that cycle. A scoreboard queue holds the expected words with their start and end marks, and the monitor compares each one at the falling edge where the consumer takes it.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  localparam int LINE_W = 9;
  localparam int STEP_W = 4;
  localparam int SEL_W  = 4;
  localparam int RSV_W  = 3;
  localparam int CMD_W  = SEL_W + RSV_W + 3 + STEP_W + 2 * LINE_W;

  typedef struct packed {
    logic [SEL_W-1:0]  bufsel;
    logic [RSV_W-1:0]  rsvd;
    logic              op_clr;
    logic              op_wr;
    logic              op_rd;
    logic [STEP_W-1:0] step;
    logic [LINE_W-1:0] last;
    logic [LINE_W-1:0] first;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRIME = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_FULL  = 3'd4
  } xfer_st_e;
endpackage

// File: rtl/pktbuf_rst_sync.sv
module pktbuf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign srst_n = s1_q;
endmodule

// File: rtl/pktbuf_cmd_decode.sv
module pktbuf_cmd_decode
  import pktbuf_pkg::*;
#(
  parameter int BUF_IDX = 0
) (
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_go,
  output logic              acc_clr,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic [LINE_W-1:0] first,
  output logic [LINE_W-1:0] last,
  output logic [STEP_W-1:0] step
);
  cmd_t cmd;
  logic hit;

  always_comb begin
    cmd     = cmd_t'(cmd_word);
    hit     = cmd_go && (cmd.bufsel == SEL_W'(BUF_IDX)) && (cmd.rsvd == '0);
    acc_clr = hit && cmd.op_clr;
    acc_wr  = hit && !cmd.op_clr && cmd.op_wr;
    acc_rd  = hit && !cmd.op_clr && !cmd.op_wr && cmd.op_rd;
    first   = cmd.first;
    last    = cmd.last;
    step    = cmd.step;
  end
endmodule

// File: rtl/pktbuf_line_ctr.sv
module pktbuf_line_ctr
  import pktbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [LINE_W-1:0] first_i,
  input  logic [LINE_W-1:0] last_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [LINE_W-1:0] line_o,
  output logic [LINE_W-1:0] line_nxt_o,
  output logic              at_last_o,
  output logic              first_o
);
  logic [LINE_W-1:0] line_q, line_d, last_q, last_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              fst_q, fst_d;
  logic              upd_en;

  assign line_nxt_o = line_q + LINE_W'(step_q);

  always_comb begin
    upd_en = load || adv;
    line_d = line_q;
    last_d = last_q;
    step_d = step_q;
    fst_d  = fst_q;
    if (load) begin
      line_d = first_i;
      last_d = last_i;
      step_d = step_i;
      fst_d  = 1'b1;
    end else if (adv) begin
      line_d = line_nxt_o;
      fst_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      last_q <= '0;
      step_q <= '0;
      fst_q  <= 1'b0;
    end else if (upd_en) begin
      line_q <= line_d;
      last_q <= last_d;
      step_q <= step_d;
      fst_q  <= fst_d;
    end
  end

  assign line_o    = line_q;
  assign at_last_o = (line_q == last_q);
  assign first_o   = fst_q;
endmodule

// File: rtl/pktbuf_xfer_fsm.sv
module pktbuf_xfer_fsm
  import pktbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     acc_clr,
  input  logic     acc_wr,
  input  logic     acc_rd,
  input  logic     at_last,
  input  logic     rd_strobe,
  input  logic     rd_last,
  input  logic     rd_abort,
  input  logic     wr_strobe,
  input  logic     wr_last,
  input  logic     wr_abort,
  output xfer_st_e state,
  output logic     done,
  output logic     error,
  output logic     adv,
  output logic     commit
);
  xfer_st_e st_q, st_d;
  logic     done_q, done_d, err_q, err_d;

  always_comb begin
    st_d   = st_q;
    done_d = done_q;
    err_d  = err_q;
    adv    = 1'b0;
    commit = 1'b0;
    if (acc_clr || acc_wr || acc_rd) begin
      done_d = 1'b0;
      err_d  = 1'b0;
      if (acc_clr)     st_d = ST_IDLE;
      else if (acc_wr) st_d = ST_WR;
      else             st_d = ST_PRIME;
    end else begin
      unique case (st_q)
        ST_PRIME: st_d = ST_RD;
        ST_RD: begin
          if (rd_abort) begin
            st_d  = ST_IDLE;
            err_d = 1'b1;
          end else if (rd_last) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else if (rd_strobe) begin
            if (at_last) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              adv = 1'b1;
            end
          end
        end
        ST_WR: begin
          if (wr_abort) begin
            st_d  = ST_IDLE;
            err_d = 1'b1;
          end else begin
            if (wr_strobe) begin
              commit = 1'b1;
              if (at_last) st_d = ST_FULL;
              else         adv  = 1'b1;
            end
            if (wr_last) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          end
        end
        ST_FULL: begin
          if (wr_abort || wr_strobe) begin
            st_d  = ST_IDLE;
            err_d = 1'b1;
          end else if (wr_last) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign state = st_q;
  assign done  = done_q;
  assign error = err_q;
endmodule

// File: rtl/pktbuf_dma.sv
module pktbuf_dma
  import pktbuf_pkg::*;
#(
  parameter int BUF_IDX = 0,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_go,
  output logic              done_o,
  output logic              error_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [LINE_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_strobe_i,
  input  logic              wr_last_i,
  input  logic              wr_abort_i,
  output logic              wr_ready_o,
  output logic              wr_full_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rd_strobe_i,
  input  logic              rd_last_i,
  input  logic              rd_abort_i,
  output logic              rd_avail_o,
  output logic              rd_sop_o,
  output logic              rd_eop_o
);
  logic              rst_sync_n;
  logic              acc_clr, acc_wr, acc_rd;
  logic [LINE_W-1:0] c_first, c_last, line, line_nxt;
  logic [STEP_W-1:0] c_step;
  logic              at_last, first_flag, adv, commit;
  xfer_st_e          state;

  pktbuf_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  pktbuf_cmd_decode #(.BUF_IDX(BUF_IDX)) u_dec (
    .cmd_word (cmd_word),
    .cmd_go   (cmd_go),
    .acc_clr  (acc_clr),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd),
    .first    (c_first),
    .last     (c_last),
    .step     (c_step)
  );

  pktbuf_line_ctr u_line (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (acc_wr || acc_rd),
    .adv        (adv),
    .first_i    (c_first),
    .last_i     (c_last),
    .step_i     (c_step),
    .line_o     (line),
    .line_nxt_o (line_nxt),
    .at_last_o  (at_last),
    .first_o    (first_flag)
  );

  pktbuf_xfer_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_clr   (acc_clr),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .at_last   (at_last),
    .rd_strobe (rd_strobe_i),
    .rd_last   (rd_last_i),
    .rd_abort  (rd_abort_i),
    .wr_strobe (wr_strobe_i),
    .wr_last   (wr_last_i),
    .wr_abort  (wr_abort_i),
    .state     (state),
    .done      (done_o),
    .error     (error_o),
    .adv       (adv),
    .commit    (commit)
  );

  always_comb begin
    ram_en_o    = (state == ST_PRIME) || ((state == ST_RD) && adv) || commit;
    ram_we_o    = commit;
    ram_addr_o  = (state == ST_RD) ? line_nxt : line;
    ram_wdata_o = wr_data_i;
    rd_data_o   = ram_rdata_i;
    rd_avail_o  = (state == ST_RD);
    rd_sop_o    = rd_avail_o && first_flag;
    rd_eop_o    = rd_avail_o && at_last;
    wr_ready_o  = (state == ST_WR);
    wr_full_o   = (state == ST_FULL);
  end
endmodule

// File: rtl/pktbuf_dma_chk.sv
module pktbuf_dma_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_go,
  input logic done_o,
  input logic error_o,
  input logic ram_en_o,
  input logic ram_we_o,
  input logic wr_ready_o,
  input logic wr_full_o,
  input logic rd_avail_o,
  input logic rd_sop_o,
  input logic rd_eop_o,
  input logic rd_strobe_i,
  input logic rd_abort_i
);
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o)); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cmd_go) |=> done_o); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (error_o && !cmd_go) |=> error_o); // R9
  AST_WE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (wr_ready_o && ram_en_o)); // R6
  AST_FULL_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_full_o) |-> $past(ram_we_o)); // R7
  AST_SOP_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_avail_o) |-> rd_sop_o); // R3
  AST_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_avail_o) |-> ($past(ram_en_o) && !$past(ram_we_o))); // R3
  AST_RAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_avail_o && !rd_strobe_i) |-> !ram_en_o); // R4
  AST_EOP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_eop_o && rd_strobe_i && !cmd_go && !rd_abort_i) |=> done_o); // R5
endmodule

bind pktbuf_dma pktbuf_dma_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmd_go      (cmd_go),
  .done_o      (done_o),
  .error_o     (error_o),
  .ram_en_o    (ram_en_o),
  .ram_we_o    (ram_we_o),
  .wr_ready_o  (wr_ready_o),
  .wr_full_o   (wr_full_o),
  .rd_avail_o  (rd_avail_o),
  .rd_sop_o    (rd_sop_o),
  .rd_eop_o    (rd_eop_o),
  .rd_strobe_i (rd_strobe_i),
  .rd_abort_i  (rd_abort_i)
);

// File: tb/pktbuf_dma_bench.sv
`timescale 1ns/1ps
module pktbuf_dma_bench;
  localparam logic [3:0] BUF = 4'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_go = 1'b0;
  logic        done_o, error_o, ram_en_o, ram_we_o;
  logic [8:0]  ram_addr_o;
  logic [31:0] ram_wdata_o, ram_rdata_i, rd_data_o;
  logic [31:0] wr_data_i = '0;
  logic        wr_strobe_i = 1'b0, wr_last_i = 1'b0, wr_abort_i = 1'b0;
  logic        rd_strobe_i = 1'b0, rd_last_i = 1'b0, rd_abort_i = 1'b0;
  logic        wr_ready_o, wr_full_o, rd_avail_o, rd_sop_o, rd_eop_o;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct { logic [31:0] d; logic s; logic e; } exp_t;
  exp_t exp_q[$];
  logic [31:0] mem [512];

  always #4 clk = ~clk;

  pktbuf_dma #(.BUF_IDX(3)) u_pktbuf_dma (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_go(cmd_go),
    .done_o(done_o), .error_o(error_o),
    .ram_en_o(ram_en_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
    .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
    .wr_data_i(wr_data_i), .wr_strobe_i(wr_strobe_i), .wr_last_i(wr_last_i),
    .wr_abort_i(wr_abort_i), .wr_ready_o(wr_ready_o), .wr_full_o(wr_full_o),
    .rd_data_o(rd_data_o), .rd_strobe_i(rd_strobe_i), .rd_last_i(rd_last_i),
    .rd_abort_i(rd_abort_i), .rd_avail_o(rd_avail_o), .rd_sop_o(rd_sop_o),
    .rd_eop_o(rd_eop_o)
  );

  function automatic logic [31:0] pat(input logic [8:0] a);
    return {7'h2B, a, 16'hA55A ^ {7'b0, a}};
  endfunction

  // RAM model: synchronous read, output held while disabled, filled in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= pat(9'(i));
      ram_rdata_i <= '0;
    end else if (ram_en_o) begin
      if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
      else          ram_rdata_i <= mem[ram_addr_o];
    end
  end

  function automatic logic [31:0] mk(input logic [3:0] sel, input logic c, w, r,
                                     input logic [3:0] st, input logic [8:0] l, f);
    return {sel, 3'b000, c, w, r, st, l, f};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard monitor: compare each word as the consumer takes it
  always @(negedge clk) begin
    if (rst_n && rd_strobe_i && rd_avail_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected word", rd_data_o, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rd_data_o == e.d, "R4 data", rd_data_o, e.d);
        chk(rd_sop_o == e.s, "R3 sop", {31'b0, rd_sop_o}, {31'b0, e.s});
        chk(rd_eop_o == e.e, "R5 eop", {31'b0, rd_eop_o}, {31'b0, e.e});
      end
    end
  end

  task automatic send_cmd(input logic [31:0] w);
    @(posedge clk); #1;
    cmd_word = w; cmd_go = 1'b1;
    @(posedge clk); #1;
    cmd_go = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] f, l, input logic [3:0] st, input int gap);
    logic [8:0] a;
    int n;
    a = f; n = 0;
    forever begin
      exp_q.push_back('{pat(a), (n == 0), (a == l)});
      n++;
      if (a == l) break;
      a = a + 9'(st);
    end
    send_cmd(mk(BUF, 1'b0, 1'b0, 1'b1, st, l, f));
    @(negedge clk);
    chk(ram_en_o && !ram_we_o && ram_addr_o == f, "R3 prefetch", {23'b0, ram_addr_o}, {23'b0, f});
    @(negedge clk);
    chk(rd_avail_o && rd_sop_o && rd_data_o == pat(f), "R3 first word", rd_data_o, pat(f));
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1; rd_strobe_i = 1'b0;
        @(negedge clk);
        chk(!ram_en_o, "R4 quiet", {31'b0, ram_en_o}, 32'h0);
      end
      @(posedge clk); #1; rd_strobe_i = 1'b1;
      @(negedge clk);
      chk(ram_en_o == (i != n - 1), "R4 fetch on strobe", {31'b0, ram_en_o}, {31'b0, (i != n - 1)});
    end
    @(posedge clk); #1; rd_strobe_i = 1'b0;
    @(negedge clk);
    chk(done_o && !error_o && !rd_avail_o, "R5 done", {30'b0, done_o, rd_avail_o}, 32'h2);
    chk(exp_q.size() == 0, "R4 all words", 32'(exp_q.size()), 32'h0);
  endtask

  task automatic do_write(input logic [8:0] f, l, input logic [3:0] st, input int n,
                          input logic [31:0] base);
    send_cmd(mk(BUF, 1'b0, 1'b1, 1'b0, st, l, f));
    @(negedge clk);
    chk(wr_ready_o && !wr_full_o, "R6 ready", {30'b0, wr_ready_o, wr_full_o}, 32'h2);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; wr_strobe_i = 1'b1; wr_data_i = base + 32'(i);
      @(negedge clk);
      chk(ram_en_o && ram_we_o && ram_addr_o == 9'(f + i * st), "R6 write addr",
          {23'b0, ram_addr_o}, 32'(9'(f + i * st)));
    end
    @(posedge clk); #1; wr_strobe_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++)
      chk(mem[9'(f + i * st)] == base + 32'(i), "R6 stored", mem[9'(f + i * st)], base + 32'(i));
  endtask

  task automatic run_all;
    // R1 reset
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!wr_ready_o && !wr_full_o && !done_o && !error_o && !ram_en_o && !rd_avail_o,
        "R1 reset", {26'b0, wr_ready_o, wr_full_o, done_o, error_o, ram_en_o, rd_avail_o}, 32'h0);

    // R2 other buffer and nonzero reserved bits are ignored
    send_cmd(mk(4'd5, 1'b0, 1'b0, 1'b1, 4'd1, 9'd14, 9'd10));
    @(negedge clk);
    chk(!ram_en_o && !rd_avail_o, "R2 other buffer", {31'b0, ram_en_o}, 32'h0);
    send_cmd(mk(BUF, 1'b0, 1'b1, 1'b0, 4'd1, 9'd14, 9'd10) | 32'h0200_0000);
    @(negedge clk);
    chk(!wr_ready_o && !ram_en_o, "R2 reserved bits", {31'b0, wr_ready_o}, 32'h0);

    // R3 R4 R5 read with gaps, R12 stride, single line
    do_read(9'd10, 9'd14, 4'd1, 1);
    do_read(9'd20, 9'd28, 4'd2, 0);
    do_read(9'd40, 9'd40, 4'd1, 0);

    // R6 R7 fill to full, then R8 producer finished
    do_write(9'd100, 9'd103, 4'd1, 4, 32'hC0DE_0000);
    chk(wr_full_o && !wr_ready_o, "R7 full", {30'b0, wr_full_o, wr_ready_o}, 32'h2);
    @(posedge clk); #1; wr_last_i = 1'b1;
    @(posedge clk); #1; wr_last_i = 1'b0;
    @(negedge clk);
    chk(done_o && !error_o && !wr_full_o, "R8 producer finished", {31'b0, done_o}, 32'h1);

    // R9 hold across idle cycles and a command for another buffer
    send_cmd(mk(4'd5, 1'b1, 1'b0, 1'b0, 4'd1, 9'd0, 9'd0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done_o && !error_o, "R9 done held", {30'b0, done_o, error_o}, 32'h2);

    // R12 write stride, R7 overflow past last line
    do_write(9'd200, 9'd206, 4'd3, 3, 32'hBEEF_0100);
    chk(wr_full_o && !done_o, "R7 full after stride", {31'b0, wr_full_o}, 32'h1);
    @(posedge clk); #1; wr_strobe_i = 1'b1; wr_data_i = 32'hDEAD_DEAD;
    @(negedge clk);
    chk(!ram_we_o, "R7 no write when full", {31'b0, ram_we_o}, 32'h0);
    @(posedge clk); #1; wr_strobe_i = 1'b0;
    @(negedge clk);
    chk(error_o && !done_o, "R7 overflow error", {30'b0, error_o, done_o}, 32'h2);
    chk(mem[9'd209] == pat(9'd209), "R7 line past range untouched", mem[9'd209], pat(9'd209));

    // R10 clear drops flags
    send_cmd(mk(BUF, 1'b1, 1'b0, 1'b0, 4'd0, 9'd0, 9'd0));
    @(negedge clk);
    chk(!error_o && !done_o && !wr_ready_o && !wr_full_o && !rd_avail_o, "R10 clear",
        {27'b0, error_o, done_o, wr_ready_o, wr_full_o, rd_avail_o}, 32'h0);

    // R8 producer abort blocks the write in that cycle
    do_write(9'd300, 9'd310, 4'd1, 2, 32'h1234_0000);
    @(posedge clk); #1; wr_strobe_i = 1'b1; wr_abort_i = 1'b1; wr_data_i = 32'hFFFF_FFFF;
    @(negedge clk);
    chk(!ram_we_o, "R8 abort blocks write", {31'b0, ram_we_o}, 32'h0);
    @(posedge clk); #1; wr_strobe_i = 1'b0; wr_abort_i = 1'b0;
    @(negedge clk);
    chk(error_o && !done_o && !wr_ready_o, "R8 producer abort", {30'b0, error_o, done_o}, 32'h2);
    chk(mem[9'd302] == pat(9'd302), "R8 aborted line untouched", mem[9'd302], pat(9'd302));

    // R8 early producer finish
    do_write(9'd320, 9'd330, 4'd1, 3, 32'h5555_0000);
    @(posedge clk); #1; wr_last_i = 1'b1;
    @(posedge clk); #1; wr_last_i = 1'b0;
    @(negedge clk);
    chk(done_o && !error_o && !wr_ready_o, "R8 short packet done", {30'b0, done_o, error_o}, 32'h2);

    // R8 consumer abort and consumer finish
    send_cmd(mk(BUF, 1'b0, 1'b0, 1'b1, 4'd1, 9'd60, 9'd50));
    @(negedge clk);
    @(negedge clk);
    chk(!done_o && rd_avail_o, "R9 flags cleared by command", {30'b0, done_o, rd_avail_o}, 32'h1);
    @(posedge clk); #1; rd_abort_i = 1'b1;
    @(posedge clk); #1; rd_abort_i = 1'b0;
    @(negedge clk);
    chk(error_o && !done_o && !rd_avail_o, "R8 consumer abort", {30'b0, error_o, done_o}, 32'h2);
    send_cmd(mk(BUF, 1'b0, 1'b0, 1'b1, 4'd1, 9'd70, 9'd60));
    @(negedge clk);
    @(negedge clk);
    @(posedge clk); #1; rd_last_i = 1'b1;
    @(posedge clk); #1; rd_last_i = 1'b0;
    @(negedge clk);
    chk(done_o && !error_o && !rd_avail_o, "R8 consumer finished", {30'b0, done_o, error_o}, 32'h2);

    // R11 operation priority
    send_cmd(mk(BUF, 1'b1, 1'b1, 1'b0, 4'd1, 9'd401, 9'd400));
    @(negedge clk);
    chk(!wr_ready_o && !done_o, "R11 clear beats write", {31'b0, wr_ready_o}, 32'h0);
    send_cmd(mk(BUF, 1'b0, 1'b1, 1'b1, 4'd1, 9'd401, 9'd400));
    @(negedge clk);
    chk(wr_ready_o && !ram_en_o, "R11 write beats read", {30'b0, wr_ready_o, ram_en_o}, 32'h2);
    send_cmd(mk(BUF, 1'b0, 1'b0, 1'b0, 4'd1, 9'd450, 9'd440));
    @(posedge clk); #1; wr_strobe_i = 1'b1; wr_data_i = 32'hABCD_0400;
    @(negedge clk);
    chk(wr_ready_o && ram_we_o && ram_addr_o == 9'd400, "R11 empty op ignored",
        {23'b0, ram_addr_o}, 32'd400);
    @(posedge clk); #1; wr_strobe_i = 1'b0;
    send_cmd(mk(BUF, 1'b1, 1'b0, 1'b0, 4'd0, 9'd0, 9'd0));
    repeat (2) @(posedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule